// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Register Banking

This block sits beside a simple in-order CPU pipeline and decides the cycle in which a pending interrupt is taken. There are three request lines: a non-maskable pin, a user break and a combined on-chip peripheral request. A request is held off while the current instruction sits in a branch delay slot. It is also held off while a multi-cycle instruction runs. A divide that is in progress is not waited for: it is cancelled, and the interrupt is taken in the same cycle.

Once a request is taken, the block plays out the entry sequence one slot per cycle. The output for each slot is a stage code (execute or memory access), a memory-access strobe, and a pulse that starts the fetch of the first handler instruction. A bank counter records how many register banks are in use. When banking is enabled and every bank is already full, registers cannot be saved. The sequence then takes the long restore path, which has 19 extra memory-access slots, and a sticky overflow flag is set. Software clears the flag with a write strobe.

The accept cycle counts as the decode slot, and the fetch slot comes before it. The short path therefore spans eight stages in total and the long path spans twenty-seven.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, stage is 00, accept and fetch_start are 0, bank_ovf is 0 and bank_level is 0.
- R2: With several requests in one cycle, only one is taken, in the priority order non-maskable, then user break, then peripheral. accept_src reports the taken source in the accept cycle: 01 for non-maskable, 10 for user break, 11 for peripheral, and 00 when nothing is taken.
- R3: accept stays 0 while in_delay_slot is 1, even with requests pending. The request is taken in the first cycle after in_delay_slot falls.
- R4: While multi_busy is 1 and div_busy is 0, accept stays 0. When multi_busy falls, the request is taken with div_cancel at 0.
- R5: With div_busy at 1, a pending request is taken at once, whatever multi_busy is. div_cancel pulses in the accept cycle.
- R6: On the short path, stage shows the codes EX EX MA MA MA EX (EX = 01, MA = 10) in the six cycles after accept, and then returns to 00.
- R7: On the long path, stage shows EX EX MA MA MA EX followed by 19 MA codes in the 25 cycles after accept, and then returns to 00.
- R8: fetch_start is 1 only in the fifth cycle after accept, which is the third MA slot.
- R9: mem_strobe is 1 exactly in the cycles where stage is MA.
- R10: Each entry taken with bank_en at 1 raises bank_level by one, up to NUM_BANKS. An entry taken with bank_en at 0 leaves bank_level unchanged and uses the short path, even when the banks are full.
- R11: An entry taken with bank_en at 1 while bank_level equals NUM_BANKS takes the long path and sets bank_ovf from the next cycle. bank_ovf stays set until a bo_clr pulse. A set in the same cycle as bo_clr wins.
- R12: No request is taken while an entry sequence is still emitting slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_nmi | input | 1 | Non-maskable interrupt request |
| req_ubrk | input | 1 | User break request |
| req_peri | input | 1 | On-chip peripheral interrupt request |
| in_delay_slot | input | 1 | Current instruction is in a branch delay slot |
| multi_busy | input | 1 | Multi-cycle instruction still executing |
| div_busy | input | 1 | Divide instruction in progress (cancellable) |
| bank_en | input | 1 | Register banking enabled |
| bo_clr | input | 1 | Software write strobe clearing the overflow flag |
| accept | output | 1 | Interrupt taken this cycle |
| accept_src | output | 2 | Code of the taken source |
| div_cancel | output | 1 | Cancel the running divide |
| stage | output | 2 | Slot code: 00 none, 01 EX, 10 MA |
| mem_strobe | output | 1 | Memory-access slot this cycle |
| fetch_start | output | 1 | Start the fetch of the handler's first instruction |
| bank_level | output | LVL_W | Number of banks in use |
| bank_ovf | output | 1 | Sticky bank-overflow flag |

## Verification
A wrong slot index or path-length register shows up directly on stage and mem_strobe. It appears either as a missing or extra slot, or as a pattern that switches between the 6-slot and 25-slot shapes. This is visible one cycle after accept and at the latest when the sequence should end. A bank counter that is off by one does not show up on the trace until the entry that should overflow. The bench therefore reads bank_level after every entry and counts sixteen banked entries. Gating faults show up on accept in the very cycle the blocking condition is present.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        STG_NONE = 2'b00,
        STG_EX   = 2'b01,
        STG_MA   = 2'b10
    } stage_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_NMI  = 2'b01,
        SRC_UBRK = 2'b10,
        SRC_PERI = 2'b11
    } src_e;

    localparam int SLOT_W     = 5;
    localparam int BASE_SLOTS = 6;
    localparam int EXTRA_MA   = 19;
    localparam int FETCH_SLOT = 4;
    localparam logic [SLOT_W-1:0] SHORT_LAST = SLOT_W'(BASE_SLOTS - 1);
    localparam logic [SLOT_W-1:0] LONG_LAST  = SLOT_W'(BASE_SLOTS + EXTRA_MA - 1);

    // slot index after accept -> stage code
    function automatic stage_e slot_stage(input logic [SLOT_W-1:0] idx);
        if (idx < SLOT_W'(2))                       return STG_EX;
        else if (idx < SLOT_W'(5))                  return STG_MA;
        else if (idx == SLOT_W'(BASE_SLOTS - 1))    return STG_EX;
        else                                        return STG_MA;
    endfunction

endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
    import irq_seq_pkg::*;
(
    input  logic req_nmi,
    input  logic req_ubrk,
    input  logic req_peri,
    input  logic in_delay_slot,
    input  logic multi_busy,
    input  logic div_busy,
    input  logic seq_busy,
    output logic take,
    output logic cancel_div,
    output src_e take_src
);

    src_e winner;
    logic window_open;

    always_comb begin
        if (req_nmi)       winner = SRC_NMI;
        else if (req_ubrk) winner = SRC_UBRK;
        else if (req_peri) winner = SRC_PERI;
        else               winner = SRC_NONE;
    end

    // a running divide can be abandoned; other multi-cycle work cannot
    assign window_open = !seq_busy && !in_delay_slot && (!multi_busy || div_busy);
    assign take        = window_open && (winner != SRC_NONE);
    assign cancel_div  = take && div_busy;
    assign take_src    = take ? winner : SRC_NONE;

endmodule

// File: rtl/irq_bank_ctl.sv
module irq_bank_ctl #(
    parameter int NUM_BANKS = 15,
    localparam int LVL_W = $clog2(NUM_BANKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             bank_en,
    input  logic             bo_clr,
    output logic             ovf_now,
    output logic [LVL_W-1:0] level,
    output logic             bo_flag
);

    localparam logic [LVL_W-1:0] FULL = LVL_W'(NUM_BANKS);

    logic full;
    assign full    = (level == FULL);
    assign ovf_now = bank_en && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= '0;
            bo_flag <= 1'b0;
        end else begin
            if (take && ovf_now)      bo_flag <= 1'b1;
            else if (bo_clr)          bo_flag <= 1'b0;
            if (take && bank_en && !full) level <= level + 1'b1;
        end
    end

    // R10
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= FULL);

    // R10
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        (take && bank_en && !full) |=> (level == $past(level) + 1'b1));

endmodule

// File: rtl/irq_slot_seq.sv
module irq_slot_seq
    import irq_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   long_path,
    output logic   busy,
    output stage_e stage,
    output logic   mem_strobe,
    output logic   fetch_start
);

    logic              active;
    logic [SLOT_W-1:0] idx;
    logic [SLOT_W-1:0] last;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            last   <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            last   <= long_path ? LONG_LAST : SHORT_LAST;
        end else if (active) begin
            if (idx == last) active <= 1'b0;
            else             idx    <= idx + 1'b1;
        end
    end

    assign busy        = active;
    assign stage       = active ? slot_stage(idx) : STG_NONE;
    assign mem_strobe  = (stage == STG_MA);
    assign fetch_start = active && (idx == SLOT_W'(FETCH_SLOT));

    // R12
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (active && idx != last) |=> active);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int NUM_BANKS = 15,
    localparam int LVL_W = $clog2(NUM_BANKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_nmi,
    input  logic             req_ubrk,
    input  logic             req_peri,
    input  logic             in_delay_slot,
    input  logic             multi_busy,
    input  logic             div_busy,
    input  logic             bank_en,
    input  logic             bo_clr,
    output logic             accept,
    output logic [1:0]       accept_src,
    output logic             div_cancel,
    output logic [1:0]       stage,
    output logic             mem_strobe,
    output logic             fetch_start,
    output logic [LVL_W-1:0] bank_level,
    output logic             bank_ovf
);

    logic   seq_busy;
    logic   ovf_now;
    src_e   src_w;
    stage_e stage_w;

    irq_accept_gate u_gate (
        .req_nmi       (req_nmi),
        .req_ubrk      (req_ubrk),
        .req_peri      (req_peri),
        .in_delay_slot (in_delay_slot),
        .multi_busy    (multi_busy),
        .div_busy      (div_busy),
        .seq_busy      (seq_busy),
        .take          (accept),
        .cancel_div    (div_cancel),
        .take_src      (src_w)
    );

    irq_bank_ctl #(.NUM_BANKS(NUM_BANKS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .take    (accept),
        .bank_en (bank_en),
        .bo_clr  (bo_clr),
        .ovf_now (ovf_now),
        .level   (bank_level),
        .bo_flag (bank_ovf)
    );

    irq_slot_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .long_path   (ovf_now),
        .busy        (seq_busy),
        .stage       (stage_w),
        .mem_strobe  (mem_strobe),
        .fetch_start (fetch_start)
    );

    assign accept_src = src_w;
    assign stage      = stage_w;

    // R12
    accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> (stage_w == STG_NONE));

    // R6
    first_slot_ex_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (stage_w == STG_EX));

    // R8
    fetch_after_ma_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> (mem_strobe && $past(mem_strobe) && $past(mem_strobe, 2)
                         && $past(stage_w, 3) == STG_EX));

    // R11
    bo_set_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && bank_en && bank_level == LVL_W'(NUM_BANKS)) |=> bank_ovf);

    // R5
    cancel_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
        div_cancel |-> (accept && src_w != SRC_NONE));

    // R3
    delay_slot_block_chk: assert property (@(posedge clk) disable iff (rst)
        in_delay_slot |-> !accept);

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_nmi = 0, req_ubrk = 0, req_peri = 0;
    logic in_delay_slot = 0, multi_busy = 0, div_busy = 0;
    logic bank_en = 0, bo_clr = 0;
    logic       accept, div_cancel, mem_strobe, fetch_start, bank_ovf;
    logic [1:0] accept_src, stage;
    logic [3:0] bank_level;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst(rst),
        .req_nmi(req_nmi), .req_ubrk(req_ubrk), .req_peri(req_peri),
        .in_delay_slot(in_delay_slot), .multi_busy(multi_busy), .div_busy(div_busy),
        .bank_en(bank_en), .bo_clr(bo_clr),
        .accept(accept), .accept_src(accept_src), .div_cancel(div_cancel),
        .stage(stage), .mem_strobe(mem_strobe), .fetch_start(fetch_start),
        .bank_level(bank_level), .bank_ovf(bank_ovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_code(input int i);
        if (i < 2)       return 2'b01;
        else if (i < 5)  return 2'b10;
        else if (i == 5) return 2'b01;
        else             return 2'b10;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive requests at a negedge, check the accept cycle, drop them next negedge
    task automatic fire(input logic n, input logic u, input logic p,
                        input logic [1:0] exp_src, input logic exp_cancel, input string tag);
        @(negedge clk);
        req_nmi = n; req_ubrk = u; req_peri = p;
        #1;
        chk(tag, accept, 1'b1);
        chk(tag, accept_src, exp_src);
        chk("R5", div_cancel, exp_cancel);
        @(negedge clk);
        req_nmi = 0; req_ubrk = 0; req_peri = 0;
        div_busy = 0; multi_busy = 0;
    endtask

    // called at the negedge of slot 0
    task automatic check_trace(input logic long_path, input logic hold_req);
        int n;
        n = long_path ? 25 : 6;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            if (hold_req) req_peri = 1'b1;
            #1;
            chk(long_path ? "R7" : "R6", stage, exp_code(i));
            chk("R9", mem_strobe, exp_code(i) == 2'b10);
            chk("R8", fetch_start, i == 4);
            if (hold_req) chk("R12", accept, 1'b0);
        end
        @(negedge clk);
        req_peri = 1'b0;
        #1;
        chk(long_path ? "R7" : "R6", stage, 2'b00);
        chk("R9", mem_strobe, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1", stage, 2'b00);
        chk("R1", accept, 1'b0);
        chk("R1", fetch_start, 1'b0);
        chk("R1", bank_ovf, 1'b0);
        chk("R1", bank_level, 4'd0);
    endtask

    task automatic t_priority();
        fire(1, 1, 1, 2'b01, 1'b0, "R2");
        check_trace(1'b0, 1'b1);
        fire(0, 1, 1, 2'b10, 1'b0, "R2");
        check_trace(1'b0, 1'b0);
        fire(0, 0, 1, 2'b11, 1'b0, "R2");
        check_trace(1'b0, 1'b0);
    endtask

    task automatic t_delay_slot();
        @(negedge clk);
        in_delay_slot = 1; req_peri = 1;
        #1; chk("R3", accept, 1'b0);
        @(negedge clk);
        #1; chk("R3", accept, 1'b0);
        chk("R3", stage, 2'b00);
        in_delay_slot = 0; req_peri = 0;
        fire(0, 0, 1, 2'b11, 1'b0, "R3");
        check_trace(1'b0, 1'b0);
    endtask

    task automatic t_multi();
        @(negedge clk);
        multi_busy = 1; req_ubrk = 1;
        #1; chk("R4", accept, 1'b0);
        @(negedge clk);
        #1; chk("R4", accept, 1'b0);
        chk("R4", stage, 2'b00);
        multi_busy = 0; req_ubrk = 0;
        fire(0, 1, 0, 2'b10, 1'b0, "R4");
        check_trace(1'b0, 1'b0);
    endtask

    task automatic t_divide();
        @(negedge clk);
        multi_busy = 1; div_busy = 1;
        fire(1, 0, 0, 2'b01, 1'b1, "R5");
        check_trace(1'b0, 1'b0);
    endtask

    task automatic t_banks();
        do_reset();
        bank_en = 0;
        fire(0, 0, 1, 2'b11, 1'b0, "R10");
        chk("R10", bank_level, 4'd0);
        check_trace(1'b0, 1'b0);
        bank_en = 1;
        for (int k = 1; k <= 15; k++) begin
            fire(0, 0, 1, 2'b11, 1'b0, "R10");
            check_trace(1'b0, 1'b0);
            chk("R10", bank_level, k);
            chk("R11", bank_ovf, 1'b0);
        end
        fire(0, 0, 1, 2'b11, 1'b0, "R11");
        chk("R11", bank_ovf, 1'b1);
        check_trace(1'b1, 1'b0);
        chk("R10", bank_level, 4'd15);
        repeat (3) @(negedge clk);
        #1; chk("R11", bank_ovf, 1'b1);
        bo_clr = 1;
        @(negedge clk);
        bo_clr = 0;
        #1; chk("R11", bank_ovf, 1'b0);
        bo_clr = 1;
        fire(1, 0, 0, 2'b01, 1'b0, "R11");
        bo_clr = 0;
        #1; chk("R11", bank_ovf, 1'b1);
        check_trace(1'b1, 1'b0);
        bank_en = 0;
        fire(0, 1, 0, 2'b10, 1'b0, "R10");
        check_trace(1'b0, 1'b0);
        chk("R10", bank_level, 4'd15);
        chk("R11", bank_ovf, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_priority();
        t_delay_slot();
        t_multi();
        t_divide();
        t_banks();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule